// File: doc/BRIEF.md
# Three-Wire Serial Register Bus Master

This block lets a host run one single-byte register access at a time on a target that sits on a three-wire serial bus. The three wires are a chip-enable, a serial clock and one data line that both sides share. A host pulses `start` together with a direction flag, a command/address byte and, for writes, a data byte. The block frames the whole access with chip-enable and shifts every bit least significant bit first. For a read, it releases the data line after the command byte so the target can answer. When the access is over it returns the collected byte and pulses `done`.

Every serial clock level lasts `HALF_CYC` system clocks. Each outgoing bit changes only while the serial clock is low, so the target latches it on the next rising edge. In the read phase the block samples the line `SETTLE_CYC` system clocks after each falling edge, which gives the target time to move the line. A write and a read both take sixteen serial clock pulses and one trailing low half-period. An access therefore lasts a fixed 33 × `HALF_CYC` system clocks from the accepting edge to `done`.

Top module: `rtc3w_master`

## Requirements
- R1: After reset, and at any time reset is asserted, `ce`, `sclk` and `dio_out` are low, `dio_oe` is high, `busy` and `done` are low and `rd_data` is 0.
- R2: A `start` seen while idle is accepted on that clock edge. In the next cycle `busy` and `ce` are high and `sclk` is low. A `start` seen while `busy` is high changes neither the bits sent nor the timing of the running access.
- R3: A write (`rd_req` = 0) gives exactly 16 rising `sclk` edges while `ce` stays high. The bits seen on `dio_out` at those edges are `cmd` bit 0 through bit 7, then `wr_data` bit 0 through bit 7.
- R4: `dio_out` changes only while `sclk` is low. It holds its value for the whole high half-period.
- R5: Each `sclk` level lasts `HALF_CYC` system clocks. `done` goes high 33 × `HALF_CYC` clocks after the edge that accepted `start`.
- R6: A read (`rd_req` = 1) drives `cmd` bit 0 to bit 7 on the first 8 rising edges with `dio_oe` high. `dio_oe` goes low at the falling edge after the 8th rise and stays low for 16 × `HALF_CYC` clocks. It rises again at the falling edge after the 16th rise, and a read also gives 16 rises in total.
- R7: During a read, one bit of `dio_in` is sampled `SETTLE_CYC` clocks after each of the 8 read-phase falling edges. The bits are assembled shifting right with each new bit entering bit 7, so the first bit received ends in bit 0 of `rd_data`.
- R8: `done` is high for exactly one cycle. That is the first cycle in which `ce` is low again; in that cycle `sclk` is low and `dio_oe` is high. `sclk` is never high while `ce` is low.
- R9: `rd_data` changes only in the cycle `done` rises after a read. A write leaves it unchanged.
- R10: `dio_oe` is never high while the target is allowed to drive the line, which is from the falling edge after the 8th rise to the falling edge after the 16th rise of a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an access; taken only while idle |
| rd_req | input | 1 | 1 = read access, 0 = write access |
| cmd | input | DATA_W | Command/address byte |
| wr_data | input | DATA_W | Byte to write |
| rd_data | output | DATA_W | Byte collected by the last completed read |
| done | output | 1 | One-cycle pulse at the end of an access |
| busy | output | 1 | Access in progress |
| ce | output | 1 | Serial chip-enable |
| sclk | output | 1 | Serial clock |
| dio_out | output | 1 | Data value driven onto the shared line |
| dio_oe | output | 1 | Data line output-enable (1 = block drives) |
| dio_in | input | 1 | Data line value as seen at the pin |

## Verification
A bit counter that slips or a sequencer stuck in one state shows at the pins straight away. The rise count per access is no longer 16, and `done` lands away from its fixed 33 × `HALF_CYC` point, so the end-of-access check catches it before the next access starts. A wrong direction decision is caught by the bench's target model in the very cycle it happens. This covers an output-enable released one half-period late, or re-driven too early. A fault in the receive shifter or in the frame bit select shows as a byte mismatch on the same access. A fault in the latch of the result shows as `rd_data` drifting across a later write.

// File: rtl/rtc3w_pkg.sv
package rtc3w_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2,
    ST_TAIL = 2'd3
  } rtc3w_state_e;

endpackage

// File: rtl/rtc3w_halftimer.sv
module rtc3w_halftimer #(
  parameter int HALF_CYC   = 4,
  parameter int SETTLE_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic half_end,
  output logic settle_hit
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);
  localparam logic [CW-1:0] SETL = CW'(SETTLE_CYC);

  logic [CW-1:0] cnt;

  assign half_end   = run && (cnt == LAST);
  assign settle_hit = run && (cnt == SETL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (restart || half_end) begin
      cnt <= '0;
    end else if (run) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R5
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

  // R5
  half_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (half_end && !restart) |=> (cnt == '0));

endmodule

// File: rtl/rtc3w_rxshift.sv
module rtc3w_rxshift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              sample,
  input  logic              bit_in,
  output logic [DATA_W-1:0] acc
);
  function automatic logic [DATA_W-1:0] shift_in_msb(
    input logic [DATA_W-1:0] cur, input logic b);
    return {b, cur[DATA_W-1:1]};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
    end else if (clear) begin
      acc <= '0;
    end else if (sample) begin
      acc <= shift_in_msb(acc, bit_in);
    end
  end

  // R7
  rx_msb_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && !clear) |=> (acc[DATA_W-1] == $past(bit_in)));

endmodule

// File: rtl/rtc3w_seq.sv
module rtc3w_seq
  import rtc3w_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rd_req,
  input  logic [DATA_W-1:0] cmd,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              half_end,
  input  logic              settle_hit,
  input  logic [DATA_W-1:0] rx_acc,
  output logic              start_acc,
  output logic              sample_en,
  output logic              run,
  output logic              busy,
  output logic              done,
  output logic              ce,
  output logic              sclk,
  output logic              dout,
  output logic              oe,
  output logic [DATA_W-1:0] rd_data
);
  localparam int FRAME_BITS = 2 * DATA_W;
  localparam int KW = $clog2(FRAME_BITS);
  localparam logic [KW-1:0] K_LAST = KW'(FRAME_BITS - 1);
  localparam logic [KW-1:0] K_RX   = KW'(DATA_W);

  rtc3w_state_e          state;
  logic [KW-1:0]         bit_k;
  logic [FRAME_BITS-1:0] frame_q;
  logic                  rw_q;
  logic [KW-1:0]         k_nxt;

  function automatic logic in_rx_slot(input logic rd, input logic [KW-1:0] k);
    return rd && (k >= K_RX);
  endfunction

  function automatic logic frame_bit(input logic [FRAME_BITS-1:0] f,
                                     input logic [KW-1:0] k);
    return f[k];
  endfunction

  assign k_nxt     = bit_k + 1'b1;
  assign busy      = (state != ST_IDLE);
  assign run       = busy;
  assign start_acc = (state == ST_IDLE) && start;
  assign sample_en = (state == ST_LOW) && in_rx_slot(rw_q, bit_k) && settle_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bit_k   <= '0;
      frame_q <= '0;
      rw_q    <= 1'b0;
      ce      <= 1'b0;
      sclk    <= 1'b0;
      dout    <= 1'b0;
      oe      <= 1'b1;
      done    <= 1'b0;
      rd_data <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            frame_q <= {wr_data, cmd};
            rw_q    <= rd_req;
            bit_k   <= '0;
            ce      <= 1'b1;
            sclk    <= 1'b0;
            dout    <= cmd[0];
            oe      <= 1'b1;
            state   <= ST_LOW;
          end
        end
        ST_LOW: begin
          if (half_end) begin
            sclk  <= 1'b1;
            state <= ST_HIGH;
          end
        end
        ST_HIGH: begin
          if (half_end) begin
            sclk <= 1'b0;
            if (bit_k == K_LAST) begin
              dout  <= 1'b0;
              oe    <= 1'b1;
              state <= ST_TAIL;
            end else begin
              bit_k <= k_nxt;
              oe    <= !in_rx_slot(rw_q, k_nxt);
              dout  <= in_rx_slot(rw_q, k_nxt) ? 1'b0 : frame_bit(frame_q, k_nxt);
              state <= ST_LOW;
            end
          end
        end
        ST_TAIL: begin
          if (half_end) begin
            ce    <= 1'b0;
            done  <= 1'b1;
            state <= ST_IDLE;
            if (rw_q) rd_data <= rx_acc;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1
  idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> (!ce && !sclk && !dout && oe));

  // R2
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || $stable(frame_q)));

  // R4
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(dout));

  // R6
  oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sclk) && (state == ST_LOW) && rw_q && (bit_k >= K_RX)) |-> !oe);

  // R10
  oe_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |-> !oe);

  // R8
  done_one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_ce_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!ce && $past(ce) && oe));

  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(rd_data));

endmodule

// File: rtl/rtc3w_master.sv
module rtc3w_master #(
  parameter int DATA_W     = 8,
  parameter int HALF_CYC   = 4,
  parameter int SETTLE_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rd_req,
  input  logic [DATA_W-1:0] cmd,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic              busy,
  output logic              ce,
  output logic              sclk,
  output logic              dio_out,
  output logic              dio_oe,
  input  logic              dio_in
);
  logic              half_end;
  logic              settle_hit;
  logic              start_acc;
  logic              sample_en;
  logic              run;
  logic [DATA_W-1:0] rx_acc;

  rtc3w_halftimer #(
    .HALF_CYC  (HALF_CYC),
    .SETTLE_CYC(SETTLE_CYC)
  ) timer_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .restart   (start_acc),
    .half_end  (half_end),
    .settle_hit(settle_hit)
  );

  rtc3w_rxshift #(
    .DATA_W(DATA_W)
  ) rx_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (start_acc),
    .sample(sample_en),
    .bit_in(dio_in),
    .acc   (rx_acc)
  );

  rtc3w_seq #(
    .DATA_W(DATA_W)
  ) seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .rd_req    (rd_req),
    .cmd       (cmd),
    .wr_data   (wr_data),
    .half_end  (half_end),
    .settle_hit(settle_hit),
    .rx_acc    (rx_acc),
    .start_acc (start_acc),
    .sample_en (sample_en),
    .run       (run),
    .busy      (busy),
    .done      (done),
    .ce        (ce),
    .sclk      (sclk),
    .dout      (dio_out),
    .oe        (dio_oe),
    .rd_data   (rd_data)
  );

  // R8
  ce_sclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |-> !sclk);

  // R2
  start_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && ce && !sclk));

endmodule

// File: tb/rtc3w_master_tb.sv
module rtc3w_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW     = 8;
  localparam int HALF   = 4;
  localparam int SETTLE = 2;
  localparam int XFER_CYC = 33 * HALF + 1;

  // {rd_req, cmd, wr_data, target reply}
  localparam logic [24:0] VEC [0:5] = '{
    {1'b0, 8'h80, 8'h5A, 8'h00},
    {1'b1, 8'h81, 8'h77, 8'hC3},
    {1'b0, 8'h8E, 8'h00, 8'h00},
    {1'b1, 8'hFF, 8'h00, 8'h01},
    {1'b0, 8'h01, 8'hFF, 8'h00},
    {1'b1, 8'h00, 8'hEE, 8'hA5}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          rd_req = 1'b0;
  logic [DW-1:0] cmd = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          done, busy, ce, sclk, dio_out, dio_oe, dio_in;

  int checks = 0;
  int failures = 0;

  // target model state
  logic          cur_rw = 1'b0;
  logic [DW-1:0] rb_cur = '0;
  logic          slave_en = 1'b0;
  logic          slave_bit = 1'b0;
  logic          sclk_p = 1'b0, ce_p = 1'b0, dout_p = 1'b0;
  logic [15:0]   cap = '0;
  int rises = 0, ncap = 0, oe_low = 0, hold_err = 0, oe_err = 0;
  logic [DW-1:0] exp_rd = '0;

  assign dio_in = dio_oe ? dio_out : (slave_en ? slave_bit : 1'b1);

  always #(CLK_PERIOD / 2) clk = ~clk;

  rtc3w_master #(.DATA_W(DW), .HALF_CYC(HALF), .SETTLE_CYC(SETTLE)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_req(rd_req), .cmd(cmd),
    .wr_data(wr_data), .rd_data(rd_data), .done(done), .busy(busy), .ce(ce),
    .sclk(sclk), .dio_out(dio_out), .dio_oe(dio_oe), .dio_in(dio_in)
  );

  always @(negedge clk) begin
    if (!rst_n) begin
      slave_en = 1'b0;
    end else begin
      if (ce && !ce_p) begin
        rises = 0; ncap = 0; cap = '0; oe_low = 0;
      end
      if (ce && sclk && !sclk_p) begin
        if (dio_oe) begin
          cap = {dio_out, cap[15:1]};
          ncap++;
        end
        rises++;
      end
      if (ce && !sclk && sclk_p) begin
        if (cur_rw && rises >= 8 && rises <= 15) begin
          slave_en = 1'b1;
          slave_bit = rb_cur[rises-8];
        end else begin
          slave_en = 1'b0;
        end
      end
      if (!ce) slave_en = 1'b0;
      if (ce && !dio_oe) oe_low++;
      if (sclk && sclk_p && dio_out != dout_p) hold_err++;
      if (dio_oe && slave_en) oe_err++;
    end
    sclk_p = sclk; ce_p = ce; dout_p = dio_out;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_xfer(input logic rw_i, input logic [DW-1:0] c,
                          input logic [DW-1:0] w, input logic [DW-1:0] rb,
                          input bit inject);
    int n;
    int h0, o0;
    h0 = hold_err; o0 = oe_err;
    cur_rw = rw_i; rb_cur = rb;
    @(negedge clk);
    rd_req = rw_i; cmd = c; wr_data = w; start = 1'b1;
    @(negedge clk);
    start = 1'b0; n = 1;
    check(busy && ce && !sclk, "R2 start taken", {busy, ce, sclk}, 3'b110);
    while (!done && n < 4 * XFER_CYC) begin
      @(negedge clk);
      n++;
      if (inject && n == 20) begin
        start = 1'b1; rd_req = ~rw_i; cmd = ~c; wr_data = ~w;
      end else if (inject && n == 21) begin
        start = 1'b0;
      end
    end
    check(n == XFER_CYC, "R5 done timing", n, XFER_CYC);
    check(!ce && !sclk && dio_oe, "R8 pins at done", {ce, sclk, dio_oe}, 3'b001);
    check(rises == 16, "R3 rise count", rises, 16);
    check(hold_err == h0, "R4 bit held while high", hold_err - h0, 0);
    check(oe_err == o0, "R10 no drive contention", oe_err - o0, 0);
    if (rw_i) begin
      exp_rd = rb;
      check(ncap == 8 && cap[15:8] == c, "R6 command bits of read", {ncap[7:0], cap[15:8]}, {8'd8, c});
      check(oe_low == 16 * HALF, "R6 release window", oe_low, 16 * HALF);
      check(rd_data == exp_rd, "R7 read byte", rd_data, exp_rd);
    end else begin
      check(ncap == 16 && cap == {w, c}, "R3 write bits", cap, {w, c});
      check(oe_low == 0, "R6 write keeps drive", oe_low, 0);
      check(rd_data == exp_rd, "R9 write keeps rd_data", rd_data, exp_rd);
    end
    @(negedge clk);
    check(!done && !busy, "R8 done single cycle", {done, busy}, 2'b00);
    check(rd_data == exp_rd, "R9 rd_data stable", rd_data, exp_rd);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    failures++;
    $display("FAIL R5 watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!ce && !sclk && !dio_out && dio_oe && !busy && !done && rd_data == 0,
          "R1 state in reset", {ce, sclk, dio_out, dio_oe, busy, done}, 6'b000100);
    rst_n = 1'b1;
    @(negedge clk);
    check(!ce && !sclk && !dio_out && dio_oe && !busy && !done && rd_data == 0,
          "R1 idle after reset", {ce, sclk, dio_out, dio_oe, busy, done}, 6'b000100);

    for (int i = 0; i < 6; i++) begin
      run_xfer(VEC[i][24], VEC[i][23:16], VEC[i][15:8], VEC[i][7:0], 1'b0);
    end

    // R2 start while busy has no effect, on a write and on a read
    run_xfer(1'b0, 8'h3C, 8'h96, 8'h00, 1'b1);
    run_xfer(1'b1, 8'hA1, 8'h00, 8'h6B, 1'b1);

    // R1 reset in the middle of an access
    cur_rw = 1'b1; rb_cur = 8'hFF;
    @(negedge clk);
    rd_req = 1'b1; cmd = 8'h55; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (90) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(!ce && !sclk && !dio_out && dio_oe && !busy && rd_data == 0,
          "R1 reset mid access", {ce, sclk, dio_out, dio_oe, busy}, 5'b00010);
    @(negedge clk);
    rst_n = 1'b1;
    exp_rd = '0;
    @(negedge clk);
    run_xfer(1'b1, 8'h10, 8'h00, 8'h80, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule